// File: doc/BRIEF.md
# Sequenced 64-bit Integer Multiplier

This block multiplies two 64-bit integers by passing the four 32x32 half-products through one shared, pipelined widening multiplier. It does not use a full 64x64 array. When a start is accepted, the block captures both operands and turns each one into a magnitude, taking the per-operand signedness flags into account. It then issues the low-by-low, low-by-high, high-by-low and high-by-high products on four consecutive cycles. As each product leaves the multiplier pipeline, it is added into a 128-bit accumulator at its weight: bit 0, bit 32 for both cross terms, and bit 64.

After the last product has been added, one more cycle negates the sum when exactly one operand was negative. The same cycle selects either the lower or the upper 64 bits. The block then raises `done` for one cycle. The selected word stays on `result` until the next operation completes. All four combinations of low/high word and signed/unsigned operands are available, including mixed signed-by-unsigned. A client raises `start` with the operands whenever `busy` is low. A start raised while the block is busy is ignored.

Top module: `mulseq_top`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: A start seen while `busy` is low is accepted at that clock edge. `busy` is 1 from the next cycle on and goes low at the same edge where `done` rises.
- R3: `done` is high for exactly one cycle. It follows the (MUL_LAT+5)-th rising edge, counted from the accepting edge as edge 0. With the default MUL_LAT=3 this is the 8th edge.
- R4: With `selHigh`=0, `result` is bits [63:0] of the full 128-bit product.
- R5: With `selHigh`=1, `result` is bits [127:64] of the full 128-bit product.
- R6: `aSigned`=1 makes `opA` a two's-complement value and `aSigned`=0 makes it unsigned. `bSigned` does the same for `opB`. All four pairings give the mathematically correct product.
- R7: A start raised while `busy` is high is ignored. It starts no operation and produces no extra `done` pulse.
- R8: `result` does not change except in the cycle in which `done` is high.
- R9: `opA`, `opB`, `aSigned`, `bSigned` and `selHigh` are sampled only at the accepting edge. Changing them later has no effect on the result.
- R10: Carries from the cross-term sums reach the upper word. For example, unsigned all-ones times all-ones gives 0xFFFFFFFFFFFFFFFE in the upper word and 0x0000000000000001 in the lower word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; accepted when busy is low |
| opA | input | 2*HALF_W (64) | Multiplicand |
| opB | input | 2*HALF_W (64) | Multiplier |
| aSigned | input | 1 | Treat opA as two's complement |
| bSigned | input | 1 | Treat opB as two's complement |
| selHigh | input | 1 | 1: upper product word, 0: lower product word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 2*HALF_W (64) | Selected product word, held between pulses |

## Verification
After the accepting edge, `busy` is checked on the following falling edge. `done` is due exactly MUL_LAT+5 edges later. The bench counts edges one at a time and compares the edge on which `done` shows against that number, so an early or late pulse is a mismatch rather than a timeout. On the falling edge after the pulse, the bench checks that `done` is low again and that `result` has held its value. The product value is compared while `done` is high. A reduced 6-bit instance is swept over every operand pair, with each pairing of sign and word modes and with occasional re-starts and operand changes mid-operation. A full-width instance with a different pipeline latency covers the carry-heavy corner vectors.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } ctrl_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       load;      // capture operands, clear accumulator
    logic       issue;     // feed one half-product into the multiplier
    logic [1:0] issueSel;  // 0: lo*lo, 1: loA*hiB, 2: hiA*loB, 3: hi*hi
    logic       finish;    // fix sign, select word, update result
  } ctrl_strobe_t;

endpackage

// File: rtl/mulseq_mult_pipe.sv
module mulseq_mult_pipe #(
  parameter int HALF_W  = 32,
  parameter int MUL_LAT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          inTag,
  input  logic [HALF_W-1:0]   inA,
  input  logic [HALF_W-1:0]   inB,
  output logic                outValid,
  output logic [1:0]          outTag,
  output logic [2*HALF_W-1:0] outProd
);
  localparam int PROD_W = 2 * HALF_W;

  logic [PROD_W-1:0] prodNow;
  logic [PROD_W-1:0] prodQ  [MUL_LAT];
  logic [1:0]        tagQ   [MUL_LAT];
  logic              validQ [MUL_LAT];

  assign prodNow = PROD_W'(inA) * PROD_W'(inB);

  for (genvar s = 0; s < MUL_LAT; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ[0] <= 1'b0;
          tagQ[0]   <= '0;
          prodQ[0]  <= '0;
        end else begin
          validQ[0] <= inValid;
          tagQ[0]   <= inTag;
          prodQ[0]  <= prodNow;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ[s] <= 1'b0;
          tagQ[s]   <= '0;
          prodQ[s]  <= '0;
        end else begin
          validQ[s] <= validQ[s-1];
          tagQ[s]   <= tagQ[s-1];
          prodQ[s]  <= prodQ[s-1];
        end
      end
    end
  end

  assign outValid = validQ[MUL_LAT-1];
  assign outTag   = tagQ[MUL_LAT-1];
  assign outProd  = prodQ[MUL_LAT-1];
endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
  import mulseq_pkg::*;
#(
  parameter int MUL_LAT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrl_strobe_t strobe,
  output logic         busy,
  output logic         done
);
  localparam int LAST_ACC = MUL_LAT + 3;             // cycle index of the final accumulate
  localparam int CNT_W    = $clog2(LAST_ACC + 1) + 1;

  ctrl_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = (state == ST_IDLE) && start;
  assign busy   = (state != ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.issue    = (state == ST_RUN) && (cnt < CNT_W'(4));
    strobe.issueSel = cnt[1:0];
    strobe.finish   = (state == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_RUN;
            cnt   <= '0;
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(LAST_ACC)) state <= ST_FINISH;
        end
        ST_FINISH: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mulseq_datapath.sv
module mulseq_datapath
  import mulseq_pkg::*;
#(
  parameter int HALF_W  = 32,
  parameter int MUL_LAT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobe,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic                aSigned,
  input  logic                bSigned,
  input  logic                selHigh,
  output logic [2*HALF_W-1:0] result
);
  localparam int OP_W   = 2 * HALF_W;
  localparam int ACC_W  = 4 * HALF_W;
  localparam int PROD_W = 2 * HALF_W;

  logic [OP_W-1:0]   magA, magB;
  logic              negRes, selHighR;
  logic [ACC_W-1:0]  acc, addend, accFixed;
  logic              negA, negB;
  logic [HALF_W-1:0] mulA, mulB;
  logic              pipeValid;
  logic [1:0]        pipeTag;
  logic [PROD_W-1:0] pipeProd;

  assign negA = aSigned & opA[OP_W-1];
  assign negB = bSigned & opB[OP_W-1];

  // Half selection for the shared multiplier
  always_comb begin
    mulA = strobe.issueSel[1] ? magA[OP_W-1:HALF_W] : magA[HALF_W-1:0];
    mulB = strobe.issueSel[0] ? magB[OP_W-1:HALF_W] : magB[HALF_W-1:0];
  end

  mulseq_mult_pipe #(.HALF_W(HALF_W), .MUL_LAT(MUL_LAT)) u_multPipe (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (strobe.issue),
    .inTag    (strobe.issueSel),
    .inA      (mulA),
    .inB      (mulB),
    .outValid (pipeValid),
    .outTag   (pipeTag),
    .outProd  (pipeProd)
  );

  // Weight each partial product by its position
  always_comb begin
    unique case (pipeTag)
      2'd0:    addend = ACC_W'(pipeProd);
      2'd3:    addend = ACC_W'(pipeProd) << (2 * HALF_W);
      default: addend = ACC_W'(pipeProd) << HALF_W;
    endcase
  end

  assign accFixed = negRes ? (~acc + 1'b1) : acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magA     <= '0;
      magB     <= '0;
      negRes   <= 1'b0;
      selHighR <= 1'b0;
      acc      <= '0;
      result   <= '0;
    end else begin
      if (strobe.load) begin
        magA     <= negA ? (~opA + 1'b1) : opA;
        magB     <= negB ? (~opB + 1'b1) : opB;
        negRes   <= negA ^ negB;
        selHighR <= selHigh;
        acc      <= '0;
      end else if (pipeValid) begin
        acc <= acc + addend;
      end
      if (strobe.finish) begin
        result <= selHighR ? accFixed[ACC_W-1:OP_W] : accFixed[OP_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mulseq_top.sv
module mulseq_top
  import mulseq_pkg::*;
#(
  parameter int HALF_W  = 32,
  parameter int MUL_LAT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic                aSigned,
  input  logic                bSigned,
  input  logic                selHigh,
  output logic                busy,
  output logic                done,
  output logic [2*HALF_W-1:0] result
);
  ctrl_strobe_t strobe;

  mulseq_ctrl #(.MUL_LAT(MUL_LAT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  mulseq_datapath #(.HALF_W(HALF_W), .MUL_LAT(MUL_LAT)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .aSigned (aSigned),
    .bSigned (bSigned),
    .selHigh (selHigh),
    .result  (result)
  );
endmodule

// File: rtl/mulseq_checker.sv
module mulseq_checker #(
  parameter int HALF_W  = 32,
  parameter int MUL_LAT = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [2*HALF_W-1:0] result
);
  localparam int DONE_LAT = MUL_LAT + 5;

  logic [15:0] sinceAccept;
  logic        inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAccept <= '0;
      inFlight    <= 1'b0;
    end else if (start && !busy) begin
      sinceAccept <= '0;
      inFlight    <= 1'b1;
    end else if (inFlight) begin
      sinceAccept <= sinceAccept + 1'b1;
      if (done) inFlight <= 1'b0;
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_busy_falls_with_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_done_single_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (inFlight && sinceAccept == 16'(DONE_LAT)));

  assert_done_needs_operation_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));
endmodule

bind mulseq_top mulseq_checker #(.HALF_W(HALF_W), .MUL_LAT(MUL_LAT)) u_mulseqChecker (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/test_mulseq_top.sv
module test_mulseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int S_HALF = 3;
  localparam int S_W    = 2 * S_HALF;
  localparam int S_LAT  = 3;
  localparam int F_LAT  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           sStart = 0, sAs = 0, sBs = 0, sSh = 0, sBusy, sDone;
  logic [S_W-1:0] sA = '0, sB = '0, sRes;
  logic           fStart = 0, fAs = 0, fBs = 0, fSh = 0, fBusy, fDone;
  logic [63:0]    fA = '0, fB = '0, fRes;

  int checks = 0;
  int fails  = 0;

  mulseq_top #(.HALF_W(S_HALF), .MUL_LAT(S_LAT)) i_mulseq_top (
    .clk(clk), .rstN(rstN), .start(sStart), .opA(sA), .opB(sB),
    .aSigned(sAs), .bSigned(sBs), .selHigh(sSh),
    .busy(sBusy), .done(sDone), .result(sRes));

  mulseq_top #(.HALF_W(32), .MUL_LAT(F_LAT)) i_mulseq_top_full (
    .clk(clk), .rstN(rstN), .start(fStart), .opA(fA), .opB(fB),
    .aSigned(fAs), .bSigned(fBs), .selHigh(fSh),
    .busy(fBusy), .done(fDone), .result(fRes));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] calcExpect(input bit full, input logic [63:0] a, input logic [63:0] b,
                                             input bit as, input bit bs, input bit sh);
    int w;
    logic [127:0] mask, ea, eb, p;
    w    = full ? 64 : S_W;
    mask = (128'd1 << w) - 1;
    ea   = {64'b0, a} & mask;
    eb   = {64'b0, b} & mask;
    if (as && ea[w-1]) ea = ea - (128'd1 << w);
    if (bs && eb[w-1]) eb = eb - (128'd1 << w);
    p = ea * eb;
    if (sh) p = p >> w;
    return 64'(p & mask);
  endfunction

  function automatic logic getDone(input bit full);
    return full ? fDone : sDone;
  endfunction
  function automatic logic getBusy(input bit full);
    return full ? fBusy : sBusy;
  endfunction
  function automatic logic [63:0] getRes(input bit full);
    return full ? fRes : 64'(sRes);
  endfunction

  task automatic drive(input bit full, input bit st, input logic [63:0] a, input logic [63:0] b,
                       input bit as, input bit bs, input bit sh);
    if (full) begin
      fStart = st; fA = a; fB = b; fAs = as; fBs = bs; fSh = sh;
    end else begin
      sStart = st; sA = a[S_W-1:0]; sB = b[S_W-1:0]; sAs = as; sBs = bs; sSh = sh;
    end
  endtask

  // One operation; disturb re-raises start with other operands while busy (R7, R9)
  task automatic runOp(input bit full, input logic [63:0] a, input logic [63:0] b,
                       input bit as, input bit bs, input bit sh, input bit disturb, input string req);
    int lat;
    int n;
    logic [63:0] exp, held;
    lat = full ? F_LAT + 5 : S_LAT + 5;
    exp = calcExpect(full, a, b, as, bs, sh);
    @(negedge clk);
    drive(full, 1'b1, a, b, as, bs, sh);
    @(posedge clk);
    @(negedge clk);
    check(getBusy(full) == 1'b1, "R2 busy after accept", 64'(getBusy(full)), 64'd1);
    if (disturb) drive(full, 1'b1, ~a, ~b, ~as, ~bs, ~sh);
    else         drive(full, 1'b0, a, b, as, bs, sh);
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 3) drive(full, 1'b0, ~a, ~b, ~as, ~bs, ~sh);
      if (getDone(full)) begin
        n = i;
        break;
      end
    end
    check(n == lat, "R3 done latency", 64'(n), 64'(lat));
    check(getBusy(full) == 1'b0, "R2 busy low with done", 64'(getBusy(full)), 64'd0);
    check(getRes(full) == exp, req, getRes(full), exp);
    held = getRes(full);
    @(negedge clk);
    check(getDone(full) == 1'b0, "R3 R7 single done pulse", 64'(getDone(full)), 64'd0);
    check(getRes(full) == held, "R8 result held", getRes(full), held);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(sBusy == 0 && sDone == 0, "R1 reset busy/done", {62'b0, sBusy, sDone}, 64'd0);
    check(sRes == '0, "R1 reset result", 64'(sRes), 64'd0);
    check(fBusy == 0 && fDone == 0 && fRes == 0, "R1 reset full", fRes, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(sBusy == 0 && sDone == 0 && sRes == '0, "R1 idle after reset", 64'(sRes), 64'd0);

    // R10: carry-heavy vectors on the full-width instance
    runOp(1, '1, '1, 0, 0, 1, 0, "R10 R5 all-ones unsigned high");
    runOp(1, '1, '1, 0, 0, 0, 0, "R10 R4 all-ones unsigned low");
    runOp(1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 0, 0, 1, 0, "R10 cross carry high");
    runOp(1, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 0, 0, 1, 1, "R10 R9 cross carry");
    runOp(1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 1, 1, 0, "R6 min*min high");
    runOp(1, 64'h8000_0000_0000_0000, '1, 1, 1, 0, 0, "R6 min*-1 low");
    runOp(1, 64'h8000_0000_0000_0000, '1, 1, 0, 1, 0, "R6 signed*unsigned high");
    runOp(1, '1, 64'd7, 1, 0, 1, 1, "R6 R9 -1*7 high");
    runOp(1, 64'd0, 64'hDEAD_BEEF_0123_4567, 1, 1, 1, 0, "R6 zero negative");
    for (int i = 0; i < 48; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      runOp(1, a, b, i[0], i[1], i[2], i % 5 == 0, i[2] ? "R5 R6 random high" : "R4 R6 random low");
    end

    // Exhaustive sweep on the reduced instance (R4, R5, R6, R7, R9)
    for (int a = 0; a < (1 << S_W); a++) begin
      for (int b = 0; b < (1 << S_W); b++) begin
        for (int k = 0; k < 2; k++) begin
          int idx, combo;
          idx   = a * (1 << S_W) + b;
          combo = (idx * 2 + k) % 8;
          runOp(0, 64'(a), 64'(b), combo[0], combo[1], combo[2], (idx + k) % 7 == 0,
                combo[2] ? "R5 R6 sweep high" : "R4 R6 sweep low");
        end
      end
    end

    // R7: idle block, no start, no done
    repeat (12) begin
      @(negedge clk);
      check(sDone == 0 && fDone == 0, "R7 no spurious done", {62'b0, sDone, fDone}, 64'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule